// File: doc/BRIEF.md
# Dual-Port FIFO Access Synchronizer

This block lets two masters share one byte queue: a local processor running on its own clock, and a host port that runs on an unrelated clock. Either side may push a byte into the queue or pop one from it. The host never touches the storage directly. A host access is placed into a holding register together with its direction. A request toggle is flipped, and the host then reads as busy until an acknowledgement toggle comes back through a two-stage synchronizer. On a read, the popped byte sits in the host read register when busy falls.

All real transfers between the holding registers and the storage happen on the rising edge of the processor clock. The write pointer, the read pointer and the occupancy count are updated on the falling edge of the same clock. The full and empty flags derive from that count, so they are never in motion while a transfer decides what to do. At most one transfer happens per processor cycle. A processor access always wins the cycle, and a waiting host access is carried out in the first cycle with no processor access.

Top module: `dual_port_fifo_sync`

## Requirements
- R1: While either reset is low and right after it, fifo_count is 0, fifo_empty is 1, fifo_full is 0, fifo_overrun is 0, host_busy is 0, and cpu_rd_data and host_rdata are 0.
- R2: A processor write (cpu_wr_en high at a rising edge) on a non-full queue appends cpu_wr_data, and fifo_count shows one more before the next rising edge; bytes leave in the order they entered.
- R3: A processor read (cpu_rd_en high, cpu_wr_en low) on a non-empty queue places the oldest byte on cpu_rd_data after that edge and lowers fifo_count by one; cpu_rd_data keeps its value in cycles without a processor read.
- R4: When cpu_wr_en and cpu_rd_en are both high in one cycle, only the write is carried out and cpu_rd_data does not change.
- R5: fifo_full is 1 exactly when DEPTH bytes are held; a write from either side while full is dropped, and fifo_overrun goes to 1 and stays 1 until reset.
- R6: A read from either side while the queue is empty leaves the count unchanged and returns the byte most recently popped by either side (0 if none since reset).
- R7: A host_req pulse while host_busy is 0 captures host_we and host_wdata; host_busy is 1 after that host clock edge and falls only when the transfer is done; after a host read, host_rdata holds the popped byte when host_busy falls.
- R8: A host_req pulse while host_busy is 1 is ignored: the captured direction and data do not change and no extra transfer takes place.
- R9: A host write is delivered into the queue by the processor clock and is later returned, in order, by processor reads.
- R10: A processor access in the same cycle as a waiting host access is carried out first; the host access is carried out at the first following rising edge with no processor access, so fifo_count changes by one in that cycle.
- R11: fifo_count, fifo_full and fifo_empty keep their old values in the first half of the cycle after a transfer and take the new value at the falling edge of the processor clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpu_clk | input | 1 | Processor clock; transfers on the rising edge, pointers on the falling edge |
| cpu_rst_n | input | 1 | Active-low asynchronous reset of the processor domain |
| cpu_wr_en | input | 1 | Processor push request for this cycle |
| cpu_wr_data | input | DATA_W | Byte to push |
| cpu_rd_en | input | 1 | Processor pop request for this cycle (ignored when cpu_wr_en is high) |
| cpu_rd_data | output | DATA_W | Byte from the last processor pop |
| fifo_empty | output | 1 | Queue holds no bytes |
| fifo_full | output | 1 | Queue holds DEPTH bytes |
| fifo_count | output | $clog2(DEPTH+1) | Number of bytes held |
| fifo_overrun | output | 1 | Sticky: a push was dropped because the queue was full |
| host_clk | input | 1 | Host clock, unrelated to cpu_clk |
| host_rst_n | input | 1 | Active-low asynchronous reset of the host domain |
| host_req | input | 1 | One-cycle host access request |
| host_we | input | 1 | Direction of the host access: 1 push, 0 pop |
| host_wdata | input | DATA_W | Byte for a host push |
| host_busy | output | 1 | A host access is outstanding |
| host_rdata | output | DATA_W | Byte from the last host pop |

## Verification
The hardest case to reach is the collision of a processor access with a host access that has just come through the synchronizer. The moment that happens is not visible at the ports. The bench therefore does not try to hit one exact edge. It posts a host write and keeps the processor writing on every cycle for far longer than the synchronizer latency, so the host access is certain to be waiting when the burst ends. The reference model then predicts the count stepping up by one in the very next idle cycle, and the host byte coming out last when the queue is drained.

// File: rtl/dpfifo_pkg.sv
package dpfifo_pkg;

    typedef enum logic [1:0] {
        XF_IDLE = 2'd0,
        XF_PUSH = 2'd1,
        XF_POP  = 2'd2
    } xfer_e;

    typedef enum logic {
        SRC_CPU  = 1'b0,
        SRC_HOST = 1'b1
    } src_e;

endpackage

// File: rtl/dpfifo_bit_sync.sv
module dpfifo_bit_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_d;
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            assign chain_d = d;
        end else begin : g_chain
            assign chain_d = {chain_q[STAGES-2:0], d};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/dpfifo_host_port.sv
module dpfifo_host_port #(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              host_clk,
    input  logic              host_rst_n,
    input  logic              host_req,
    input  logic              host_we,
    input  logic [DATA_W-1:0] host_wdata,
    output logic              host_busy,
    output logic [DATA_W-1:0] host_rdata,
    output logic              req_tgl,
    output logic              hb_we,
    output logic [DATA_W-1:0] hb_data,
    input  logic              ack_tgl,
    input  logic [DATA_W-1:0] rd_buf
);
    typedef struct packed {
        logic              req_tgl;
        logic              ack_seen;
        logic              hb_we;
        logic [DATA_W-1:0] hb_data;
        logic [DATA_W-1:0] rdata;
    } hst_t;

    hst_t s_d, s_q;
    logic ack_sync;
    logic ack_evt;
    logic busy;

    dpfifo_bit_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
        .clk   (host_clk),
        .rst_n (host_rst_n),
        .d     (ack_tgl),
        .q     (ack_sync)
    );

    always_comb begin
        s_d     = s_q;
        busy    = s_q.req_tgl != s_q.ack_seen;
        ack_evt = ack_sync != s_q.ack_seen;
        if (host_req && !busy) begin
            s_d.req_tgl = ~s_q.req_tgl;
            s_d.hb_we   = host_we;
            s_d.hb_data = host_wdata;
        end
        if (ack_evt) begin
            s_d.ack_seen = ack_sync;
            if (!s_q.hb_we) s_d.rdata = rd_buf;
        end
    end

    always_ff @(posedge host_clk or negedge host_rst_n) begin
        if (!host_rst_n) s_q <= '0;
        else             s_q <= s_d;
    end

    assign host_busy  = busy;
    assign host_rdata = s_q.rdata;
    assign req_tgl    = s_q.req_tgl;
    assign hb_we      = s_q.hb_we;
    assign hb_data    = s_q.hb_data;

    // R7
    req_accept_chk: assert property (@(posedge host_clk) disable iff (!host_rst_n)
        host_req && !host_busy |=> host_busy);

    // R8
    busy_ignore_chk: assert property (@(posedge host_clk) disable iff (!host_rst_n)
        host_req && host_busy |=> $stable(hb_data) && $stable(hb_we) && $stable(req_tgl));
endmodule

// File: rtl/dpfifo_xfer_core.sv
module dpfifo_xfer_core
    import dpfifo_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int DEPTH       = 16,
    parameter int SYNC_STAGES = 2,
    localparam int PTR_W      = $clog2(DEPTH),
    localparam int CNT_W      = $clog2(DEPTH + 1)
) (
    input  logic              cpu_clk,
    input  logic              cpu_rst_n,
    input  logic              cpu_wr_en,
    input  logic [DATA_W-1:0] cpu_wr_data,
    input  logic              cpu_rd_en,
    output logic [DATA_W-1:0] cpu_rd_data,
    input  logic              host_req_tgl,
    input  logic              hb_we,
    input  logic [DATA_W-1:0] hb_data,
    output logic              ack_tgl,
    output logic [DATA_W-1:0] host_rd_buf,
    output logic              fifo_empty,
    output logic              fifo_full,
    output logic [CNT_W-1:0]  fifo_count,
    output logic              fifo_overrun
);
    // state advanced on the rising edge: transfer decisions and data
    typedef struct packed {
        logic              req_seen;
        logic              hpend;
        logic              ack_tgl;
        logic [DATA_W-1:0] hrd;
        logic [DATA_W-1:0] crd;
        logic [DATA_W-1:0] last;
        logic              push;
        logic              pop;
        logic              ovr;
    } pos_t;

    // state advanced on the falling edge: pointers and occupancy
    typedef struct packed {
        logic [PTR_W-1:0] wr_ptr;
        logic [PTR_W-1:0] rd_ptr;
        logic [CNT_W-1:0] count;
    } neg_t;

    pos_t p_d, p_q;
    neg_t n_d, n_q;

    logic [DATA_W-1:0] mem_q [DEPTH];
    logic              mem_we;
    logic [DATA_W-1:0] mem_wd;
    logic [DATA_W-1:0] rd_val;
    logic              req_sync;
    logic              host_evt;
    logic              host_want;
    logic              cpu_act;
    logic              full_w;
    logic              empty_w;
    xfer_e             kind;
    src_e              src;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    dpfifo_bit_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
        .clk   (cpu_clk),
        .rst_n (cpu_rst_n),
        .d     (host_req_tgl),
        .q     (req_sync)
    );

    assign full_w  = n_q.count == CNT_W'(DEPTH);
    assign empty_w = n_q.count == '0;

    always_comb begin
        p_d       = p_q;
        p_d.push  = 1'b0;
        p_d.pop   = 1'b0;
        mem_we    = 1'b0;
        mem_wd    = cpu_wr_data;
        kind      = XF_IDLE;
        src       = SRC_CPU;
        host_evt  = req_sync != p_q.req_seen;
        host_want = host_evt | p_q.hpend;
        cpu_act   = cpu_wr_en | cpu_rd_en;
        if (host_evt) p_d.req_seen = req_sync;

        if (cpu_wr_en) begin
            kind = XF_PUSH;
        end else if (cpu_rd_en) begin
            kind = XF_POP;
        end else if (host_want) begin
            src         = SRC_HOST;
            kind        = hb_we ? XF_PUSH : XF_POP;
            mem_wd      = hb_data;
            p_d.ack_tgl = ~p_q.ack_tgl;
        end
        p_d.hpend = host_want & cpu_act;

        rd_val = empty_w ? p_q.last : mem_q[n_q.rd_ptr];

        case (kind)
            XF_PUSH: begin
                if (full_w) begin
                    p_d.ovr = 1'b1;
                end else begin
                    mem_we   = 1'b1;
                    p_d.push = 1'b1;
                end
            end
            XF_POP: begin
                if (!empty_w) p_d.pop = 1'b1;
                p_d.last = rd_val;
                if (src == SRC_CPU) p_d.crd = rd_val;
                else                p_d.hrd = rd_val;
            end
            default: ;
        endcase
    end

    always_ff @(posedge cpu_clk or negedge cpu_rst_n) begin
        if (!cpu_rst_n) p_q <= '0;
        else            p_q <= p_d;
    end

    always_ff @(posedge cpu_clk) begin
        if (mem_we) mem_q[n_q.wr_ptr] <= mem_wd;
    end

    always_comb begin
        n_d = n_q;
        if (p_q.push) begin
            n_d.wr_ptr = ptr_inc(n_q.wr_ptr);
            n_d.count  = n_q.count + 1'b1;
        end
        if (p_q.pop) begin
            n_d.rd_ptr = ptr_inc(n_q.rd_ptr);
            n_d.count  = n_q.count - 1'b1;
        end
    end

    always_ff @(negedge cpu_clk or negedge cpu_rst_n) begin
        if (!cpu_rst_n) n_q <= '0;
        else            n_q <= n_d;
    end

    assign cpu_rd_data  = p_q.crd;
    assign host_rd_buf  = p_q.hrd;
    assign ack_tgl      = p_q.ack_tgl;
    assign fifo_empty   = empty_w;
    assign fifo_full    = full_w;
    assign fifo_count   = n_q.count;
    assign fifo_overrun = p_q.ovr;

    // R5
    overrun_sticky_chk: assert property (@(posedge cpu_clk) disable iff (!cpu_rst_n)
        fifo_overrun |=> fifo_overrun);

    // R5
    count_bound_chk: assert property (@(posedge cpu_clk) disable iff (!cpu_rst_n)
        fifo_count <= CNT_W'(DEPTH));

    // R4
    wr_over_rd_chk: assert property (@(posedge cpu_clk) disable iff (!cpu_rst_n)
        cpu_wr_en && cpu_rd_en && !fifo_full |=> p_q.push && !p_q.pop && $stable(cpu_rd_data));

    // R6
    empty_read_chk: assert property (@(posedge cpu_clk) disable iff (!cpu_rst_n)
        cpu_rd_en && !cpu_wr_en && fifo_empty |=> !p_q.pop && cpu_rd_data == $past(p_q.last));

    // R10
    host_serve_chk: assert property (@(posedge cpu_clk) disable iff (!cpu_rst_n)
        p_q.hpend && !cpu_act |=> ack_tgl != $past(ack_tgl));

    // R11
    ptr_phase_chk: assert property (@(posedge cpu_clk) disable iff (!cpu_rst_n)
        p_q.push |-> fifo_count == $past(fifo_count) + 1'b1);
endmodule

// File: rtl/dual_port_fifo_sync.sv
module dual_port_fifo_sync #(
    parameter int DATA_W      = 8,
    parameter int DEPTH       = 16,
    parameter int SYNC_STAGES = 2,
    localparam int CNT_W      = $clog2(DEPTH + 1)
) (
    input  logic              cpu_clk,
    input  logic              cpu_rst_n,
    input  logic              cpu_wr_en,
    input  logic [DATA_W-1:0] cpu_wr_data,
    input  logic              cpu_rd_en,
    output logic [DATA_W-1:0] cpu_rd_data,
    output logic              fifo_empty,
    output logic              fifo_full,
    output logic [CNT_W-1:0]  fifo_count,
    output logic              fifo_overrun,
    input  logic              host_clk,
    input  logic              host_rst_n,
    input  logic              host_req,
    input  logic              host_we,
    input  logic [DATA_W-1:0] host_wdata,
    output logic              host_busy,
    output logic [DATA_W-1:0] host_rdata
);
    logic              req_tgl;
    logic              ack_tgl;
    logic              hb_we;
    logic [DATA_W-1:0] hb_data;
    logic [DATA_W-1:0] host_rd_buf;

    dpfifo_host_port #(
        .DATA_W      (DATA_W),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_host_port (
        .host_clk   (host_clk),
        .host_rst_n (host_rst_n),
        .host_req   (host_req),
        .host_we    (host_we),
        .host_wdata (host_wdata),
        .host_busy  (host_busy),
        .host_rdata (host_rdata),
        .req_tgl    (req_tgl),
        .hb_we      (hb_we),
        .hb_data    (hb_data),
        .ack_tgl    (ack_tgl),
        .rd_buf     (host_rd_buf)
    );

    dpfifo_xfer_core #(
        .DATA_W      (DATA_W),
        .DEPTH       (DEPTH),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_xfer_core (
        .cpu_clk      (cpu_clk),
        .cpu_rst_n    (cpu_rst_n),
        .cpu_wr_en    (cpu_wr_en),
        .cpu_wr_data  (cpu_wr_data),
        .cpu_rd_en    (cpu_rd_en),
        .cpu_rd_data  (cpu_rd_data),
        .host_req_tgl (req_tgl),
        .hb_we        (hb_we),
        .hb_data      (hb_data),
        .ack_tgl      (ack_tgl),
        .host_rd_buf  (host_rd_buf),
        .fifo_empty   (fifo_empty),
        .fifo_full    (fifo_full),
        .fifo_count   (fifo_count),
        .fifo_overrun (fifo_overrun)
    );
endmodule

// File: tb/dual_port_fifo_sync_bench.sv
module dual_port_fifo_sync_bench;
    localparam int DW    = 8;
    localparam int DEPTH = 16;
    localparam int CW    = $clog2(DEPTH + 1);

    logic          cpu_clk = 1'b0;
    logic          host_clk = 1'b0;
    logic          cpu_rst_n = 1'b0;
    logic          host_rst_n = 1'b0;
    logic          cpu_wr_en = 1'b0;
    logic [DW-1:0] cpu_wr_data = '0;
    logic          cpu_rd_en = 1'b0;
    logic [DW-1:0] cpu_rd_data;
    logic          fifo_empty;
    logic          fifo_full;
    logic [CW-1:0] fifo_count;
    logic          fifo_overrun;
    logic          host_req = 1'b0;
    logic          host_we = 1'b0;
    logic [DW-1:0] host_wdata = '0;
    logic          host_busy;
    logic [DW-1:0] host_rdata;

    int checks = 0;
    int fails  = 0;
    int mq[$];
    int m_last = 0;
    int m_crd  = 0;
    bit m_ovr  = 1'b0;
    bit host_done = 1'b0;
    bit finished  = 1'b0;

    always #10 cpu_clk  = ~cpu_clk;
    always #7  host_clk = ~host_clk;

    dual_port_fifo_sync #(.DATA_W(DW), .DEPTH(DEPTH), .SYNC_STAGES(2)) u_dual_port_fifo_sync (
        .cpu_clk(cpu_clk), .cpu_rst_n(cpu_rst_n), .cpu_wr_en(cpu_wr_en),
        .cpu_wr_data(cpu_wr_data), .cpu_rd_en(cpu_rd_en), .cpu_rd_data(cpu_rd_data),
        .fifo_empty(fifo_empty), .fifo_full(fifo_full), .fifo_count(fifo_count),
        .fifo_overrun(fifo_overrun), .host_clk(host_clk), .host_rst_n(host_rst_n),
        .host_req(host_req), .host_we(host_we), .host_wdata(host_wdata),
        .host_busy(host_busy), .host_rdata(host_rdata)
    );

    task automatic chk(input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    // drive just before a rising edge, update the model at the edge,
    // sample early (before the falling edge) and late (before the next rise)
    task automatic step(input bit w, input bit r, input int d, input bit cmp = 1'b1,
                        input int host_push = -1);
        int old_cnt;
        cpu_wr_en   = w;
        cpu_rd_en   = r;
        cpu_wr_data = DW'(d);
        @(posedge cpu_clk);
        old_cnt = mq.size();
        if (w) begin
            if (mq.size() == DEPTH) m_ovr = 1'b1;
            else mq.push_back(d);
        end else if (r) begin
            if (mq.size() == 0) m_crd = m_last;
            else m_crd = mq.pop_front();
            m_last = m_crd;
        end else if (host_push >= 0) begin
            if (mq.size() == DEPTH) m_ovr = 1'b1;
            else mq.push_back(host_push);
        end
        #6;
        if (cmp && (w || r || host_push >= 0))
            chk("R11 count before falling edge", int'(fifo_count), old_cnt);
        #12;
        if (cmp) begin
            chk("R2/R3 count", int'(fifo_count), mq.size());
            chk("R5 full flag", int'(fifo_full), int'(mq.size() == DEPTH));
            chk("R6 empty flag", int'(fifo_empty), int'(mq.size() == 0));
            chk("R5 overrun", int'(fifo_overrun), int'(m_ovr));
            chk("R3/R4 cpu_rd_data", int'(cpu_rd_data), m_crd);
        end
    endtask

    task automatic host_op(input bit we, input int d, input bit dup, output int rd);
        @(posedge host_clk);
        #2;
        host_req   = 1'b1;
        host_we    = we;
        host_wdata = DW'(d);
        @(posedge host_clk);
        #2;
        host_req = 1'b0;
        chk("R7 busy after request", int'(host_busy), 1);
        if (dup) begin
            host_req   = 1'b1;
            host_we    = 1'b1;
            host_wdata = 8'hEE;
            @(posedge host_clk);
            #2;
            host_req = 1'b0;
        end
        while (host_busy) begin
            @(posedge host_clk);
            #2;
        end
        rd = int'(host_rdata);
        host_done = 1'b1;
    endtask

    task automatic host_write(input int d, input bit dup);
        int unused;
        host_done = 1'b0;
        fork
            host_op(1'b1, d, dup, unused);
            begin
                while (!host_done) step(1'b0, 1'b0, 0, 1'b0);
            end
        join
        if (mq.size() == DEPTH) m_ovr = 1'b1;
        else mq.push_back(d);
        step(1'b0, 1'b0, 0);
        step(1'b0, 1'b0, 0);
    endtask

    task automatic host_read();
        int got;
        int exp;
        host_done = 1'b0;
        fork
            host_op(1'b0, 0, 1'b0, got);
            begin
                while (!host_done) step(1'b0, 1'b0, 0, 1'b0);
            end
        join
        if (mq.size() == 0) exp = m_last;
        else exp = mq.pop_front();
        m_last = exp;
        chk("R7 host read data", got, exp);
        step(1'b0, 1'b0, 0);
    endtask

    initial begin
        #3_000_000;
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int dummy;
        repeat (3) @(posedge cpu_clk);
        #5;
        cpu_rst_n  = 1'b1;
        host_rst_n = 1'b1;
        @(posedge cpu_clk);
        #18;
        // R1 reset state
        chk("R1 count", int'(fifo_count), 0);
        chk("R1 empty", int'(fifo_empty), 1);
        chk("R1 full", int'(fifo_full), 0);
        chk("R1 overrun", int'(fifo_overrun), 0);
        chk("R1 host_busy", int'(host_busy), 0);
        chk("R1 cpu_rd_data", int'(cpu_rd_data), 0);
        chk("R1 host_rdata", int'(host_rdata), 0);

        // R6 read while empty after reset returns 0
        step(1'b0, 1'b1, 0);
        // R2 / R3 basic processor traffic
        step(1'b1, 1'b0, 8'h11);
        step(1'b1, 1'b0, 8'h22);
        step(1'b1, 1'b0, 8'h33);
        step(1'b0, 1'b1, 0);
        step(1'b0, 1'b0, 0);
        // R4 write and read together: write only
        step(1'b1, 1'b1, 8'h44);

        // R9 host write, R7 host read, R8 duplicate request ignored
        host_write(8'h5A, 1'b0);
        host_read();
        host_write(8'h77, 1'b1);
        for (int i = 0; i < 4; i++) step(1'b0, 1'b1, 0);
        // R6 empty read returns last popped byte
        step(1'b0, 1'b1, 0);
        chk("R6 last value after drain", int'(cpu_rd_data), 8'h77);

        // R10 processor burst collides with a host write
        host_done = 1'b0;
        fork
            host_op(1'b1, 8'hC3, 1'b0, dummy);
            begin
                for (int k = 0; k < 12; k++) step(1'b1, 1'b0, 8'h10 + k);
                chk("R10 host waits behind processor", int'(host_busy), 1);
                step(1'b0, 1'b0, 0, 1'b1, 8'hC3);
                chk("R10 host served in first idle cycle", int'(fifo_count), 13);
                while (!host_done) step(1'b0, 1'b0, 0);
            end
        join
        for (int k = 0; k < 13; k++) step(1'b0, 1'b1, 0);
        chk("R10 host byte drained last", int'(cpu_rd_data), 8'hC3);

        // R5 fill, overflow, sticky overrun
        for (int k = 0; k < DEPTH; k++) step(1'b1, 1'b0, 8'h80 + k);
        chk("R5 full at depth", int'(fifo_full), 1);
        step(1'b1, 1'b0, 8'hFF);
        step(1'b0, 1'b1, 0);
        step(1'b1, 1'b0, 8'hA0);
        step(1'b0, 1'b0, 0);
        chk("R5 overrun stays set", int'(fifo_overrun), 1);
        host_write(8'hBB, 1'b0);
        host_read();
        for (int k = 0; k < DEPTH; k++) step(1'b0, 1'b1, 0);
        host_read();
        chk("R6 host empty read returns last", int'(host_rdata), 8'hA0);
        step(1'b0, 1'b0, 0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule